// File: doc/BRIEF.md
# Sticky Security Attribution Checker

This block keeps one attribution bit for each protected target: a group of peripherals, the GPIO ports and the on-chip SRAM sections. A bit at 0 means the target belongs to the secure world. A bit at 1 means non-secure software may use it. Software can only move a target toward non-secure, by writing a 1. The only way back to secure is a reset. The bit vectors drive the output ports directly, and each one can be read back through a small register port.

The block also judges SRAM accesses. SRAM is visible through two aliases, each made of equal 8 KB sections: a secure window and a non-secure window with the same layout. Each access request carries an address and a non-secure flag. A small Moore state machine registers the verdict, so it appears one cycle after the request.

The state machine has three states: `ST_IDLE` (no request), `ST_ALLOW` (grant) and `ST_DENY` (violation). Every cycle it enters one of them from any state:
- it goes to `ST_IDLE` when no request is present;
- it goes to `ST_DENY` on a non-secure request to the secure alias, or to a non-secure section that is still secure;
- it goes to `ST_ALLOW` on every other request.

Top module: `secattr_guard`

## Requirements
- R1: After reset every attribution bit is 0 (secure), and both `acc_grant` and `acc_viol` are low.
- R2: Writing register select 0 (peripherals), 1 (GPIO ports A to H on data bits 0 to 7) or 2 (SRAM sections 0 to 11 on data bits 0 to 11) sets bit i of that vector when data bit i is 1. The new value is visible from the next cycle.
- R3: A data bit of 0 leaves the corresponding attribution bit unchanged. No write ever returns a bit to 0.
- R4: Writes to select 3 change no vector, and reads of select 3 return 0.
- R5: A read returns the current vector of the selected group, zero-extended to 32 bits, in the same cycle.
- R6: Secure section n spans 0x2000_0000 + 0x2000*n up to one byte below the next section. Non-secure section n uses the same offsets from 0x3000_0000. There are 12 sections.
- R7: A non-secure request to any address in the secure window gives `acc_viol` high and `acc_grant` low for one cycle.
- R8: A non-secure request to the non-secure window is granted if that section's bit is 1, and raises `acc_viol` if the bit is 0.
- R9: A secure request is always granted, whatever the address.
- R10: A request whose address is outside both windows is granted and never raises a violation.
- R11: The verdict appears in the cycle after the request, and only for that cycle. Exactly one of `acc_grant` and `acc_viol` is high after a request, and neither is high after a cycle with no request.
- R12: When a write and a request fall in the same cycle, the request is judged against the attribution bits as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the attribution registers |
| reg_sel | input | 2 | Write target: 0 peripherals, 1 GPIO, 2 SRAM, 3 none |
| reg_wdata | input | 32 | Write data; each 1 bit sets a target non-secure |
| reg_rsel | input | 2 | Read select, same encoding as `reg_sel` |
| reg_rdata | output | 32 | Zero-extended vector of the selected group |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Byte address of the request |
| acc_ns | input | 1 | 1 when the request comes from non-secure software |
| periph_ns | output | 32 | Peripheral attribution vector |
| gpio_ns | output | 8 | GPIO port attribution vector |
| sram_ns | output | 12 | SRAM section attribution vector |
| acc_grant | output | 1 | Request of the previous cycle allowed |
| acc_viol | output | 1 | Request of the previous cycle blocked (violation pulse) |

## Verification
An attribution write and an access request can fall in the same cycle, and they can touch the same SRAM section. The bench provokes this by writing 1 to section 1 while it drives a non-secure request to section 1's non-secure alias in that same cycle. It expects a violation pulse, because the request must see the old secure bit. It also expects the written bit to read back as 1 afterwards. A repeat of the same request in the next cycle must then be granted, which shows that the write took effect without altering the earlier verdict.

// File: rtl/secattr_pkg.sv
package secattr_pkg;

    typedef enum logic [1:0] {
        SEL_PERIPH = 2'd0,
        SEL_GPIO   = 2'd1,
        SEL_SRAM   = 2'd2,
        SEL_NONE   = 2'd3
    } attr_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALLOW = 2'd1,
        ST_DENY  = 2'd2
    } judge_state_e;

endpackage

// File: rtl/secattr_sticky.sv
module secattr_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set_en && set_bits[i]) begin
                q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/secattr_window.sv
module secattr_window #(
    parameter logic [31:0] BASE       = 32'h2000_0000,
    parameter int unsigned SECT_BYTES = 8192,
    parameter int unsigned SECTIONS   = 12,
    parameter int unsigned IDX_W      = 4
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    localparam int unsigned SHIFT = $clog2(SECT_BYTES);
    localparam logic [31:0] SPAN  = 32'(SECTIONS * SECT_BYTES);

    logic [31:0] offset;

    always_comb begin
        offset = addr - BASE;
        hit    = (offset < SPAN);
        idx    = offset[SHIFT+IDX_W-1:SHIFT];
    end

endmodule

// File: rtl/secattr_judge.sv
module secattr_judge
    import secattr_pkg::*;
#(
    parameter int unsigned SECTIONS = 12,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_ns,
    input  logic                sec_hit,
    input  logic                ns_hit,
    input  logic [IDX_W-1:0]    ns_idx,
    input  logic [SECTIONS-1:0] sect_ns,
    output logic                grant,
    output logic                viol
);

    judge_state_e state, state_n;
    logic         sect_open;

    always_comb begin
        sect_open = ns_hit && (32'(ns_idx) < SECTIONS) && sect_ns[ns_idx];
        state_n   = ST_IDLE;
        if (req) begin
            if (!req_ns) begin
                state_n = ST_ALLOW;
            end else if (sec_hit) begin
                state_n = ST_DENY;
            end else if (ns_hit && !sect_open) begin
                state_n = ST_DENY;
            end else begin
                state_n = ST_ALLOW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: begin
                grant = 1'b0;
                viol  = 1'b0;
            end
            ST_ALLOW: begin
                grant = 1'b1;
                viol  = 1'b0;
            end
            ST_DENY: begin
                grant = 1'b0;
                viol  = 1'b1;
            end
            default: begin
                grant = 1'b0;
                viol  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/secattr_guard.sv
module secattr_guard
    import secattr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          PERIPH_W   = 32,
    parameter int          GPIO_W     = 8,
    parameter int unsigned SECTIONS   = 12,
    parameter int unsigned SECT_BYTES = 8192,
    parameter logic [31:0] SEC_BASE   = 32'h2000_0000,
    parameter logic [31:0] NS_BASE    = 32'h3000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [1:0]          reg_rsel,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                acc_valid,
    input  logic [31:0]         acc_addr,
    input  logic                acc_ns,
    output logic [PERIPH_W-1:0] periph_ns,
    output logic [GPIO_W-1:0]   gpio_ns,
    output logic [SECTIONS-1:0] sram_ns,
    output logic                acc_grant,
    output logic                acc_viol
);

    localparam int unsigned IDX_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1;

    logic             sec_hit, ns_hit;
    logic [IDX_W-1:0] ns_idx, sec_idx_unused;

    secattr_sticky #(.W(PERIPH_W)) u_periph (
        .clk(clk), .rst_n(rst_n),
        .set_en(reg_wr && (reg_sel == SEL_PERIPH)),
        .set_bits(reg_wdata[PERIPH_W-1:0]),
        .q(periph_ns)
    );

    secattr_sticky #(.W(GPIO_W)) u_gpio (
        .clk(clk), .rst_n(rst_n),
        .set_en(reg_wr && (reg_sel == SEL_GPIO)),
        .set_bits(reg_wdata[GPIO_W-1:0]),
        .q(gpio_ns)
    );

    secattr_sticky #(.W(int'(SECTIONS))) u_sram (
        .clk(clk), .rst_n(rst_n),
        .set_en(reg_wr && (reg_sel == SEL_SRAM)),
        .set_bits(reg_wdata[SECTIONS-1:0]),
        .q(sram_ns)
    );

    secattr_window #(
        .BASE(SEC_BASE), .SECT_BYTES(SECT_BYTES), .SECTIONS(SECTIONS), .IDX_W(IDX_W)
    ) u_sec_win (
        .addr(acc_addr), .hit(sec_hit), .idx(sec_idx_unused)
    );

    secattr_window #(
        .BASE(NS_BASE), .SECT_BYTES(SECT_BYTES), .SECTIONS(SECTIONS), .IDX_W(IDX_W)
    ) u_ns_win (
        .addr(acc_addr), .hit(ns_hit), .idx(ns_idx)
    );

    secattr_judge #(.SECTIONS(SECTIONS), .IDX_W(IDX_W)) u_judge (
        .clk(clk), .rst_n(rst_n),
        .req(acc_valid), .req_ns(acc_ns),
        .sec_hit(sec_hit), .ns_hit(ns_hit), .ns_idx(ns_idx),
        .sect_ns(sram_ns),
        .grant(acc_grant), .viol(acc_viol)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_rsel)
            SEL_PERIPH: reg_rdata[PERIPH_W-1:0] = periph_ns;
            SEL_GPIO:   reg_rdata[GPIO_W-1:0]   = gpio_ns;
            SEL_SRAM:   reg_rdata[SECTIONS-1:0] = sram_ns;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/secattr_guard_chk.sv
module secattr_guard_chk #(
    parameter int          DATA_W   = 32,
    parameter int          PERIPH_W = 32,
    parameter int          GPIO_W   = 8,
    parameter int unsigned SECTIONS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [1:0]          reg_sel,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                acc_valid,
    input logic                acc_ns,
    input logic [PERIPH_W-1:0] periph_ns,
    input logic [GPIO_W-1:0]   gpio_ns,
    input logic [SECTIONS-1:0] sram_ns,
    input logic                acc_grant,
    input logic                acc_viol
);

    // R3
    sram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~sram_ns & $past(sram_ns)) == '0));
    // R3
    gpio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~gpio_ns & $past(gpio_ns)) == '0));
    // R3
    periph_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~periph_ns & $past(periph_ns)) == '0));
    // R2
    sram_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=>
        ((sram_ns & $past(reg_wdata[SECTIONS-1:0])) == $past(reg_wdata[SECTIONS-1:0])));
    // R2
    gpio_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |=>
        ((gpio_ns & $past(reg_wdata[GPIO_W-1:0])) == $past(reg_wdata[GPIO_W-1:0])));
    // R2
    periph_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=>
        ((periph_ns & $past(reg_wdata[PERIPH_W-1:0])) == $past(reg_wdata[PERIPH_W-1:0])));
    // R9
    sec_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ns) |=> acc_grant);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!acc_grant && !acc_viol));
    // R11
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_grant != acc_viol));
    // R7
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_viol |-> $past(acc_valid && acc_ns));

endmodule

bind secattr_guard secattr_guard_chk #(
    .DATA_W(DATA_W), .PERIPH_W(PERIPH_W), .GPIO_W(GPIO_W), .SECTIONS(SECTIONS)
) i_chk (.*);

// File: tb/test_secattr_guard.sv
module test_secattr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_ns = 1'b0;
    logic [31:0] periph_ns;
    logic [7:0]  gpio_ns;
    logic [11:0] sram_ns;
    logic        acc_grant, acc_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secattr_guard i_secattr_guard (.*);

    // {non-secure, address, expected grant, expected violation}
    // sections 0 and 2 are opened before the walk
    localparam int NVEC = 11;
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 32'h3000_0000, 1'b1, 1'b0},  // R8 open section 0
        {1'b1, 32'h3000_2000, 1'b0, 1'b1},  // R8 closed section 1
        {1'b1, 32'h3000_5FFC, 1'b1, 1'b0},  // R6 last word of section 2
        {1'b1, 32'h2000_0000, 1'b0, 1'b1},  // R7 secure alias
        {1'b0, 32'h2000_2000, 1'b1, 1'b0},  // R9
        {1'b0, 32'h3000_2000, 1'b1, 1'b0},  // R9
        {1'b1, 32'h3001_7FFC, 1'b0, 1'b1},  // R6 section 11 closed
        {1'b1, 32'h3001_8000, 1'b1, 1'b0},  // R10 past the window
        {1'b1, 32'h2001_8000, 1'b1, 1'b0},  // R10
        {1'b1, 32'h1FFF_FFFC, 1'b1, 1'b0},  // R10 below the window
        {1'b1, 32'h2001_0004, 1'b0, 1'b1}   // R7 secure section 8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        reg_rsel = sel;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic access(input logic ns, input logic [31:0] addr,
                          input logic eg, input logic ev, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_ns = ns; acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " grant"}, {31'd0, acc_grant}, {31'd0, eg});
        chk({req, " viol"},  {31'd0, acc_viol},  {31'd0, ev});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 periph", periph_ns, 32'h0);
        chk("R1 gpio", {24'd0, gpio_ns}, 32'h0);
        chk("R1 sram", {20'd0, sram_ns}, 32'h0);
        chk("R1 outputs", {30'd0, acc_grant, acc_viol}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {30'd0, acc_grant, acc_viol}, 32'h0);

        // R2 / R5 peripheral and GPIO set, readback
        wr(2'd0, 32'h8000_0001);
        rd_chk("R2 R5 periph read", 2'd0, 32'h8000_0001);
        wr(2'd0, 32'h0000_0000);
        rd_chk("R3 periph zero write", 2'd0, 32'h8000_0001);
        wr(2'd1, 32'h0000_0F0A);
        rd_chk("R2 R5 gpio read", 2'd1, 32'h0000_000A);
        wr(2'd1, 32'h0000_0041);
        rd_chk("R3 gpio accumulate", 2'd1, 32'h0000_004B);
        // R4 null select
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk("R4 null read", 2'd3, 32'h0);
        chk("R4 periph untouched", periph_ns, 32'h8000_0001);
        chk("R4 gpio untouched", {24'd0, gpio_ns}, 32'h4B);
        chk("R4 sram untouched", {20'd0, sram_ns}, 32'h0);

        // open SRAM sections 0 and 2
        wr(2'd2, 32'h0000_0005);
        rd_chk("R2 R5 sram read", 2'd2, 32'h0000_0005);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][34], VEC[i][33:2], VEC[i][1], VEC[i][0],
                   $sformatf("R6 R7 R8 R9 R10 vec%0d", i));
        end

        // R11 no request -> both low
        @(negedge clk);
        chk("R11 idle", {30'd0, acc_grant, acc_viol}, 32'h0);

        // R12 write and request in the same cycle on section 1
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_0002;
        acc_valid = 1'b1; acc_ns = 1'b1; acc_addr = 32'h3000_2010;
        @(negedge clk);
        reg_wr = 1'b0; acc_valid = 1'b0;
        chk("R12 old bits judged viol", {31'd0, acc_viol}, 32'h1);
        chk("R12 old bits judged grant", {31'd0, acc_grant}, 32'h0);
        rd_chk("R12 write landed", 2'd2, 32'h0000_0007);
        access(1'b1, 32'h3000_2010, 1'b1, 1'b0, "R12 reaccess");

        // R3 zero write to SRAM keeps bits
        wr(2'd2, 32'h0);
        rd_chk("R3 sram zero write", 2'd2, 32'h0000_0007);

        done = 1'b1;
        finish_run();
    end

endmodule